// File: doc/BRIEF.md
# Prioritized Interrupt Vector Unit

This block gathers the seven event flags of a two-wire serial bus controller into one interrupt request and a small binary vector that names the most urgent enabled event. Each event arrives as a single-cycle pulse and latches a sticky flag. A per-event enable mask decides which flags may reach the interrupt line and the vector. The full flag word is always visible, whatever the mask says.

Software services the block by reading the vector. The read strobe clears only the flag the vector reports. The interrupt line then drops for one cycle. If other enabled flags are still pending, the line rises again, so a receiver that detects edges sees a new request for each event. A soft reset input returns every flag to zero without touching the mask. The block has no data stream, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `irq_vector_unit`

## Requirements
- R1: Flag and mask bit positions are fixed: bit 0 arbitration lost, bit 1 no-acknowledge, bit 2 registers ready, bit 3 receive ready, bit 4 transmit ready, bit 5 stop detected, bit 6 addressed as slave. The vector code of the event at bit i is i+1.
- R2: An event pulse sets its flag on the next clock edge. The flag then holds until a vector read clears it or a reset clears it. Any mask value has no effect on setting or holding a flag.
- R3: A vector read clears exactly one flag, the one whose code the vector shows in that cycle. A read while the vector is 0 clears nothing.
- R4: The vector is combinational from the flags and the mask. It equals i+1 for the lowest bit i that is both flagged and enabled, and 0 when no enabled flag is pending.
- R5: The interrupt is high when any enabled flag is pending. The exception is the cycle right after a vector read, when it is forced low.
- R6: After that low cycle, the interrupt rises again if enabled flags remain pending.
- R7: An event that arrives in the same cycle as a vector read is never lost. This holds both when the event belongs to a different flag and when it belongs to the flag being cleared.
- R8: A soft reset clears all flags on the next edge. Events that arrive in the same cycle as the soft reset are dropped.
- R9: After the asynchronous active-low reset, the flags are 0, the vector is 0 and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of all flags |
| evt_pulse | input | 7 | Event pulses, one bit per event (R1 order) |
| irq_en | input | 7 | Per-event enable mask |
| vec_rd | input | 1 | Vector read strobe, one cycle per read |
| flags | output | 7 | Sticky flag word |
| vec | output | 3 | Binary vector of the highest-priority enabled flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a vector read that coincides with new events, because the clear and the set then meet on the same flag register. The outcome depends on whether the new event hits the reported flag or another flag. The stimulus covers this in three steps. First, an exhaustive sweep loads every flag pattern under every mask and checks the vector, the cleared flag, the low cycle and the re-assertion. Second, directed cases pulse the reported flag, and then a different flag, in the same cycle as the read strobe. Third, further directed cases overlap a soft reset with events.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int unsigned EVT_N = 7;
  localparam int unsigned EV_ARB_LOST  = 0;
  localparam int unsigned EV_NO_ACK    = 1;
  localparam int unsigned EV_REGS_RDY  = 2;
  localparam int unsigned EV_RX_RDY    = 3;
  localparam int unsigned EV_TX_RDY    = 4;
  localparam int unsigned EV_STOP_SEEN = 5;
  localparam int unsigned EV_ADDRESSED = 6;

  function automatic int unsigned code_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/irqv_flag_bank.sv
module irqv_flag_bank #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic [N-1:0] evt_pulse,
  input  logic [N-1:0] clr_oh,
  output logic [N-1:0] flags
);
  logic [N-1:0] flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (soft_rst) flags_q <= '0;
    else               flags_q <= (flags_q & ~clr_oh) | evt_pulse;
  end

  assign flags = flags_q;

  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_oh)); // R3
  AST_EVT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> ((flags_q & $past(evt_pulse)) == $past(evt_pulse))); // R7
  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (flags_q == '0)); // R8
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && clr_oh == '0) |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R2
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && clr_oh != '0) |=>
      ((flags_q & $past(clr_oh) & ~$past(evt_pulse)) == '0)); // R3
endmodule

// File: rtl/irqv_prio_enc.sv
module irqv_prio_enc #(
  parameter int unsigned N  = 7,
  parameter int unsigned VW = 3
) (
  input  logic [N-1:0]  pend,
  output logic [N-1:0]  sel_oh,
  output logic [VW-1:0] code
);
  logic [N:0] seen;

  assign seen[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_chain
      assign seen[gi+1]  = seen[gi] | pend[gi];
      assign sel_oh[gi]  = pend[gi] & ~seen[gi];
    end
  endgenerate

  always_comb begin
    code = '0;
    for (int i = 0; i < N; i++) begin
      if (sel_oh[i]) code = code | VW'(i + 1);
    end
  end
endmodule

// File: rtl/irqv_irq_gen.sv
module irqv_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic vec_rd,
  input  logic any_pend,
  output logic irq
);
  logic gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= 1'b0;
    else        gap_q <= vec_rd;
  end

  assign irq = any_pend & ~gap_q;

  AST_GAP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    vec_rd |=> !irq); // R5
  AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_rd && any_pend) |=> (irq || $past(any_pend) != any_pend || vec_rd || !any_pend)); // R6
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irqv_pkg::*;
#(
  parameter int unsigned N  = EVT_N,
  parameter int unsigned VW = code_width(EVT_N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic [N-1:0]  evt_pulse,
  input  logic [N-1:0]  irq_en,
  input  logic          vec_rd,
  output logic [N-1:0]  flags,
  output logic [VW-1:0] vec,
  output logic          irq
);
  logic [N-1:0] pend;
  logic [N-1:0] sel_oh;
  logic [N-1:0] clr_oh;

  assign pend   = flags & irq_en;
  assign clr_oh = vec_rd ? sel_oh : '0;

  irqv_flag_bank #(.N(N)) u_flags (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .evt_pulse(evt_pulse), .clr_oh(clr_oh), .flags(flags)
  );

  irqv_prio_enc #(.N(N), .VW(VW)) u_enc (
    .pend(pend), .sel_oh(sel_oh), .code(vec)
  );

  irqv_irq_gen u_irq (
    .clk(clk), .rst_n(rst_n), .vec_rd(vec_rd),
    .any_pend(|pend), .irq(irq)
  );

  AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (vec == '0) |-> ((flags & irq_en) == '0)); // R4
  AST_VEC_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (vec != '0) |-> ((((flags & irq_en) >> (vec - VW'(1))) & N'(1)) != '0)); // R4
  AST_VEC_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (vec != '0) |-> (((flags & irq_en) & ((N'(1) << (vec - VW'(1))) - N'(1))) == '0)); // R4
  AST_READ_CLEARS_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && !soft_rst && vec != '0) |=>
      ((((flags & ~$past(evt_pulse)) >> ($past(vec) - VW'(1))) & N'(1)) == '0)); // R3
endmodule

// File: tb/sim_irq_vector_unit.sv
`timescale 1ns/1ps
module sim_irq_vector_unit;
  localparam int N = 7;
  localparam int VW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0;
  logic [N-1:0] evt_pulse = '0;
  logic [N-1:0] irq_en = '0;
  logic vec_rd = 1'b0;
  logic [N-1:0] flags;
  logic [VW-1:0] vec;
  logic irq;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_vector_unit u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .evt_pulse(evt_pulse),
    .irq_en(irq_en), .vec_rd(vec_rd), .flags(flags), .vec(vec), .irq(irq)
  );

  function automatic int exp_vec(input int f, input int m);
    for (int i = 0; i < N; i++) if ((((f & m) >> i) & 1) != 0) return i + 1;
    return 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    @(negedge clk) soft_rst = 1'b1;
    @(negedge clk) soft_rst = 1'b0;
  endtask

  task automatic load(input int f, input int m);
    @(negedge clk) evt_pulse = N'(f); irq_en = N'(m);
    @(negedge clk) evt_pulse = '0;
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected<190000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #1;
    // R9: state under reset
    chk("R9 flags", flags, 0); chk("R9 vec", vec, 0); chk("R9 irq", irq, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R9 flags after release", flags, 0);
    chk("R9 irq after release", irq, 0);

    // Exhaustive sweep R1 R2 R3 R4 R5 R6
    for (int f = 0; f < 128; f++) begin
      for (int m = 0; m < 128; m++) begin
        int ev, rem;
        clear_all();
        load(f, m);
        ev = exp_vec(f, m);
        chk("R2 flags set", flags, f);
        chk("R4 vec", vec, ev);
        chk("R5 irq", irq, ((f & m) != 0) ? 1 : 0);
        @(negedge clk) vec_rd = 1'b1;
        @(negedge clk) vec_rd = 1'b0;
        #1;
        rem = (ev == 0) ? f : (f & ~(1 << (ev - 1)));
        chk("R3 one flag cleared", flags, rem);
        chk("R5 gap after read", irq, 0);
        @(negedge clk); #1;
        chk("R6 rearm", irq, ((rem & m) != 0) ? 1 : 0);
        chk("R1 next code", vec, exp_vec(rem, m));
      end
    end

    // R7: event on a different flag during read
    clear_all();
    load(7'b000_0101, 7'h7f);
    chk("R1 code arb lost", vec, 1);
    @(negedge clk) vec_rd = 1'b1; evt_pulse = 7'b100_0000;
    @(negedge clk) vec_rd = 1'b0; evt_pulse = '0; #1;
    chk("R7 other flag kept", flags, 7'b100_0100);
    // R7: event on the reported flag during read
    @(negedge clk) vec_rd = 1'b1; evt_pulse = 7'b000_0100;
    @(negedge clk) vec_rd = 1'b0; evt_pulse = '0; #1;
    chk("R7 same flag re-set", flags, 7'b100_0100);
    chk("R5 gap", irq, 0);

    // R2: masked flags hold and appear when enabled
    clear_all();
    load(7'b010_0000, 7'b000_0000);
    chk("R2 masked irq", irq, 0);
    chk("R4 masked vec", vec, 0);
    @(negedge clk) vec_rd = 1'b1;
    @(negedge clk) vec_rd = 1'b0; #1;
    chk("R3 read at zero clears nothing", flags, 7'b010_0000);
    @(negedge clk) irq_en = 7'h7f; #1;
    chk("R4 unmasked vec", vec, 6);
    chk("R6 irq after unmask", irq, 1);

    // R8: soft reset drops simultaneous events
    @(negedge clk) soft_rst = 1'b1; evt_pulse = 7'b000_1000;
    @(negedge clk) soft_rst = 1'b0; evt_pulse = '0; #1;
    chk("R8 flags cleared", flags, 0);
    chk("R8 irq low", irq, 0);
    chk("R8 mask kept", exp_vec(7'h7f, irq_en), 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule